// File: doc/BRIEF.md
# Decade BCD Rate Multiplier

This block thins a stream of input clock events so that, out of every ten events, a chosen number from zero to nine is passed on. The number is a 4-bit BCD rate code. A decade counter steps once per input event. A weighted decode of the counter state decides which events pass, so the passed events are spread across the decade instead of arriving in a burst. Typical uses are fractional frequency synthesis, motor stepping rates and digital scaling.

The input clock is not used as a clock. Each falling edge of it reaches the block as a one-cycle request, `tick_i`, in the system clock domain. The block gives:
- a true pulse output and its complement;
- a one-cycle carry pulse for chaining stages;
- a level that is high while the counter rests at nine.

The controls are:
- a mask that suppresses the pulses;
- a force input that drives the true output high;
- a hold input that freezes counting;
- a clear input and a preset-to-nine input. Both act at once, and the preset wins over the clear.

Top module: `bcd_rate_mult`

## Requirements
- R1: For a rate code N from 0 to 9, a decade of ten accepted ticks that starts at counter state 0 yields exactly N pulses on `rate_o`.
- R2: For rate codes 10 to 15, bits 2 and 1 are ignored. A decade yields 8 pulses if bit 0 is 0 and 9 pulses if bit 0 is 1.
- R3: The counter steps 0..9 and wraps to 0, once per tick while not held. A tick taken in state s pulses `rate_o` high for exactly the next system cycle when state s is enabled by the rate code. The states for each bit are:
  - bit 3: every state except 4 and 9;
  - bit 2: states 1, 3, 5 and 7;
  - bit 1: states 2 and 6;
  - bit 0: state 4.
- R4: While `mask_i` is high and `force_i` is low, `rate_o` stays 0. Counting, `carry_o` and `nine_o` continue normally.
- R5: While `force_i` is high, `rate_o` is 1, whatever the mask is.
- R6: `rate_n_o` is always the inverse of `rate_o`.
- R7: In normal counting, `carry_o` gives one single-cycle pulse per decade, on the tick taken in state 9. `nine_o` is high while the state is 9, so it rises once per decade.
- R8: While `clr_i` is high and `set9_i` is low, the counter is held at 0 and `nine_o` is 0. Every tick pulses `rate_o` if rate bit 3 is 1, and none does if it is 0. `carry_o` stays 0.
- R9: While `set9_i` is high, the counter is held at 9 and `nine_o` is 1. `rate_o` gives no pulses and `carry_o` is 0. This holds even when `clr_i` is also high.
- R10: While `hold_i` is high, ticks are ignored: the state does not change and neither `rate_o` nor `carry_o` pulses.
- R11: After reset, the state is 0, `rate_o` and `carry_o` are 0, `rate_n_o` is 1 and `nine_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | One-cycle request per input clock falling edge |
| rate_i | input | 4 | BCD rate code |
| mask_i | input | 1 | Suppresses output pulses |
| force_i | input | 1 | Forces the true output high |
| hold_i | input | 1 | Freezes counting |
| clr_i | input | 1 | Clears the counter to 0 |
| set9_i | input | 1 | Presets the counter to 9; wins over clear |
| rate_o | output | 1 | Rate pulse output |
| rate_n_o | output | 1 | Complement of rate_o |
| carry_o | output | 1 | One pulse per decade for chaining |
| nine_o | output | 1 | High while the counter is at 9 |

## Verification
The assertions check, on every cycle:
- the counter step and wrap;
- the freeze under hold;
- the overrides from mask, force, clear and preset on the outputs;
- the range of the counter.

Only the bench's scenarios can show the pulse counts per decade. It runs all sixteen rate codes, checks the saturating codes above nine, counts one carry and one nine-rise per decade, and checks the exact cycle in which a single decoded pulse appears. Clear with each value of rate bit 3 and the realignment after a preset are also scenario-only checks.

// File: rtl/bcd_rate_mult.sv
module bcd_rate_mult #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [RW-1:0] rate_i,
  input  logic          mask_i,
  input  logic          force_i,
  input  logic          hold_i,
  input  logic          clr_i,
  input  logic          set9_i,
  output logic          rate_o,
  output logic          rate_n_o,
  output logic          carry_o,
  output logic          nine_o
);
  localparam logic [3:0] TOP = 4'd9;

  logic [3:0] st_q;
  logic       pulse_q, carry_q;
  logic       w8, w4, w2, w1, hit, step;

  assign step = tick_i && !hold_i && !clr_i && !set9_i;

  assign w8 = (st_q != 4'd4) && (st_q != TOP);
  assign w4 = st_q[0] && (st_q < 4'd8);
  assign w2 = (st_q == 4'd2) || (st_q == 4'd6);
  assign w1 = (st_q == 4'd4);
  assign hit = rate_i[3] ? (w8 || (rate_i[0] && w1))
                         : ((rate_i[2] && w4) || (rate_i[1] && w2) || (rate_i[0] && w1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      pulse_q <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      if (set9_i)      st_q <= TOP;
      else if (clr_i)  st_q <= '0;
      else if (step)   st_q <= (st_q == TOP) ? 4'd0 : st_q + 4'd1;

      if (set9_i)      pulse_q <= 1'b0;
      else if (clr_i)  pulse_q <= tick_i && rate_i[3];
      else             pulse_q <= step && hit;

      carry_q <= step && (st_q == TOP);
    end
  end

  assign rate_o   = force_i || (!mask_i && !set9_i && pulse_q);
  assign rate_n_o = !rate_o;
  assign carry_o  = carry_q && !set9_i && !clr_i;
  assign nine_o   = set9_i || (!clr_i && (st_q == TOP));

  // R3
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n) st_q <= TOP);
  // R3
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> st_q == (($past(st_q) == TOP) ? 4'd0 : $past(st_q) + 4'd1));
  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clr_i && !set9_i) |=> ($stable(st_q) && !carry_q));
  // R4
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i && !force_i) |-> !rate_o);
  // R5
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n) force_i |-> rate_o);
  // R9
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set9_i |-> (nine_o && !carry_o && (rate_o == force_i)));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set9_i) |-> (!nine_o && !carry_o));
endmodule

// File: tb/bcd_rate_mult_bench.sv
module bcd_rate_mult_bench;
  logic clk = 0, rst_n = 0;
  logic tick_i = 0, mask_i = 0, force_i = 0, hold_i = 0, clr_i = 0, set9_i = 0;
  logic [3:0] rate_i = 0;
  logic rate_o, rate_n_o, carry_o, nine_o;

  bcd_rate_mult u_bcd_rate_mult (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_p[$], exp_c[$], exp_n[$];
  string exp_tag[$];
  bit zero_req = 0, flush_req = 0;
  int cnt_p = 0, cnt_c = 0, cnt_n = 0;
  logic nine_prev = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (zero_req) begin cnt_p = 0; cnt_c = 0; cnt_n = 0; zero_req = 0; end
    if (rate_o) cnt_p++;
    if (carry_o) cnt_c++;
    if (nine_o && !nine_prev) cnt_n++;
    nine_prev = nine_o;
    check("R6 complement", rate_n_o, !rate_o);
    if (flush_req) begin
      check({exp_tag[0], " pulses"}, cnt_p, exp_p.pop_front());
      check({exp_tag[0], " carries"}, cnt_c, exp_c.pop_front());
      check({exp_tag[0], " nine rises"}, cnt_n, exp_n.pop_front());
      void'(exp_tag.pop_front());
      flush_req = 0;
    end
  end

  task automatic tick();
    @(posedge clk); #1 tick_i = 1;
    @(posedge clk); #1 tick_i = 0;
    @(posedge clk); #1;
  endtask

  task automatic decade(int ep, int ec, int en, string tag);
    exp_p.push_back(ep); exp_c.push_back(ec); exp_n.push_back(en); exp_tag.push_back(tag);
    @(posedge clk); #1 zero_req = 1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) tick();
    @(posedge clk); #1 flush_req = 1;
    wait (flush_req == 0);
  endtask

  task automatic realign();
    @(posedge clk); #1 clr_i = 1;
    @(posedge clk); @(posedge clk); #1 clr_i = 0;
    @(posedge clk); #1;
  endtask

  function automatic int expect_n(int code);
    if (code < 10) return code;
    return (code % 2) ? 9 : 8;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 rate_o", rate_o, 0);
    check("R11 rate_n_o", rate_n_o, 1);
    check("R11 carry_o", carry_o, 0);
    check("R11 nine_o", nine_o, 0);
    #1 rst_n = 1;

    for (int c = 0; c < 16; c++) begin
      rate_i = 4'(c);
      for (int d = 0; d < 2; d++)
        decade(expect_n(c), 1, 1, (c < 10) ? "R1 rate code" : "R2 saturating code");
    end

    rate_i = 4'd1;
    for (int i = 0; i < 4; i++) tick();
    @(posedge clk); #1 tick_i = 1;
    @(posedge clk); #1 tick_i = 0;
    @(negedge clk); check("R3 pulse cycle after tick", rate_o, 1);
    @(negedge clk); check("R3 single-cycle pulse", rate_o, 0);
    realign();

    rate_i = 4'd9; mask_i = 1;
    decade(0, 1, 1, "R4 mask");
    force_i = 1;
    @(negedge clk); check("R5 force over mask", rate_o, 1);
    mask_i = 0;
    @(negedge clk); check("R5 force", rate_o, 1);
    check("R6 force complement", rate_n_o, 0);
    force_i = 0;

    decade(9, 1, 1, "R7 carry and nine");

    hold_i = 1;
    decade(0, 0, 0, "R10 hold");
    hold_i = 0;
    decade(9, 1, 1, "R10 alignment kept after hold");

    @(posedge clk); #1 clr_i = 1; rate_i = 4'd8;
    decade(10, 0, 0, "R8 clear msb set");
    rate_i = 4'd7;
    decade(0, 0, 0, "R8 clear msb clear");
    @(negedge clk); check("R8 nine low in clear", nine_o, 0);
    #1 clr_i = 0;

    @(posedge clk); #1 set9_i = 1; rate_i = 4'd9;
    @(negedge clk); check("R9 nine on preset", nine_o, 1);
    decade(0, 0, 0, "R9 preset");
    clr_i = 1;
    @(negedge clk); check("R9 preset wins over clear", nine_o, 1);
    #1 clr_i = 0; set9_i = 0;
    @(negedge clk); check("R9 state nine after release", nine_o, 1);
    #1 tick();
    @(negedge clk); check("R9 wrap from nine", nine_o, 0);
    realign();
    decade(9, 1, 1, "R1 after realign");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule